// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter

This block sends 8-bit frames over a serial data line that runs with a clock. Frames have no start, stop or parity bits. A bus-side write places a byte in a holding register. When the shift stage is free, the byte moves into a shift register and leaves least significant bit first. The serial clock comes from one of two sources, selected by a mode input. In internal mode the block divides the system clock and drives the serial clock itself. In external mode it follows a clock applied from outside, which it synchronizes and edge-detects in the system clock domain.

The block keeps two flags: holding-register-empty and transmit-end. Each flag, ANDed with its enable input, forms an interrupt request. While the last bit of a frame is on the line, the block looks at the empty flag. If a new byte is waiting, the next frame follows with no idle gap. If not, the block stops with the data line held at the last bit and the serial clock high.

A pending overrun error, applied at an input, prevents any frame from starting. Clearing the transmit enable resets the transfer logic.

Top module: `sync_serial_tx`

## Requirements
- R1: A frame carries exactly the 8 data bits of the written byte, bit 0 first and bit 7 last, with no added framing bits.
- R2: In internal mode the serial clock goes low when a frame starts. Each half period lasts CLK_DIV system cycles. Exactly 8 rising edges occur per frame. The data output changes only when the clock falls, and is stable at each rising edge.
- R3: In external mode the data output advances one bit for each synchronized falling edge of the external clock, and does not change on its rising edges. After the eighth falling edge the frame ends. The serial clock output stays high throughout external mode.
- R4: A write clears the empty flag in the next cycle. When the byte moves into an idle shift register, the empty flag is set again one cycle later.
- R5: txi_req equals the empty flag AND txi_en, and tei_req equals the transmit-end flag AND tei_en.
- R6: A byte written before the end of the current frame's bit 7 is sent right after it. The serial clock keeps the same period across the frame boundary.
- R7: When a frame ends with no byte waiting, the transmit-end flag is set. The data output holds the level of bit 7 and the serial clock stays high until the next frame.
- R8: While ovr_err is 1, no frame starts and a written byte stays in the holding register. The frame starts once ovr_err returns to 0.
- R9: While tx_en is 0, both flags read 1, sdo and sclk_out are 1, and writes are ignored. The state seen one cycle after tx_en falls is already reset.
- R10: A write clears the transmit-end flag.
- R11: After reset both flags are 1, sdo is 1 and sclk_out is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; 0 holds the block in reset |
| int_clk_sel | input | 1 | 1: internal divided serial clock; 0: follow ext_sclk |
| ext_sclk | input | 1 | External serial clock, asynchronous to clk |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| ovr_err | input | 1 | Pending overrun error; blocks frame start |
| txi_en | input | 1 | Enable for the empty interrupt request |
| tei_en | input | 1 | Enable for the transmit-end interrupt request |
| sclk_out | output | 1 | Serial clock output (internal mode) |
| sdo | output | 1 | Serial data output |
| hre_flag | output | 1 | Holding register empty flag |
| tend_flag | output | 1 | Transmit end flag |
| txi_req | output | 1 | Empty interrupt request |
| tei_req | output | 1 | Transmit-end interrupt request |

## Verification
A write sampled at one edge lowers the empty flag at the next sample. When the shifter is idle, the flag rises again one sample later, with the serial clock already low and bit 0 on the line. The bench checks exactly those two samples. Inputs are driven and outputs read on the falling edge of the system clock.

In internal mode, serial clock rises are timed against a cycle counter and must come exactly 2*CLK_DIV cycles apart, including across frame boundaries. In external mode the effect of an external edge appears three system cycles later, after two synchronizer stages and the shift register. The bench holds each external level for six cycles and samples the data line just before the next edge.

// File: rtl/sstx_pkg.sv
package sstx_pkg;

    localparam int unsigned FRAME_BITS = 8;
    localparam int unsigned IDX_W      = $clog2(FRAME_BITS);

    typedef struct packed {
        logic                  busy;
        logic                  sclk;
        logic                  sdo;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] sreg;
    } shift_st_t;

    typedef struct packed {
        logic [FRAME_BITS-1:0] hold;
        logic                  full;
        logic                  tend;
    } hold_st_t;

endpackage

// File: rtl/sstx_edge_src.sv
module sstx_edge_src #(
    parameter int unsigned CLK_DIV     = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic int_sel,
    input  logic run,
    input  logic sclk_now,
    input  logic ext_clk,
    output logic ev_rise,
    output logic ev_fall
);
    localparam int unsigned CNT_W = $clog2(CLK_DIV + 1);

    typedef struct packed {
        logic [CNT_W-1:0]     cnt;
        logic [SYNC_STAGES:0] sync;
    } es_t;

    es_t es_d, es_q;
    logic tick;
    logic ext_rise, ext_fall;

    always_comb begin
        es_d      = es_q;
        es_d.sync = {es_q.sync[SYNC_STAGES-1:0], ext_clk};
        tick      = run && (es_q.cnt == CNT_W'(CLK_DIV - 1));
        if (!run || tick) begin
            es_d.cnt = '0;
        end else begin
            es_d.cnt = es_q.cnt + 1'b1;
        end
        ext_rise = es_q.sync[SYNC_STAGES-1] & ~es_q.sync[SYNC_STAGES];
        ext_fall = ~es_q.sync[SYNC_STAGES-1] & es_q.sync[SYNC_STAGES];
        if (int_sel) begin
            ev_rise = tick & ~sclk_now;
            ev_fall = tick & sclk_now;
        end else begin
            ev_rise = run & ext_rise;
            ev_fall = run & ext_fall;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            es_q <= '0;
        end else begin
            es_q <= es_d;
        end
    end

    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_rise && ev_fall)); // R2

endmodule

// File: rtl/sstx_shifter.sv
module sstx_shifter
    import sstx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  ovr_err,
    input  logic                  hold_full,
    input  logic [FRAME_BITS-1:0] hold_data,
    input  logic                  ev_rise,
    input  logic                  ev_fall,
    output logic                  take,
    output logic                  done,
    output logic                  busy,
    output logic                  sclk,
    output logic                  sdo
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    shift_st_t sh_d, sh_q;
    logic      at_end;
    localparam shift_st_t SH_RESET = '{busy: 1'b0, sclk: 1'b1, sdo: 1'b1,
                                       idx: '0, sreg: '0};

    always_comb begin
        sh_d   = sh_q;
        at_end = sh_q.busy && ev_fall && sh_q.sclk && (sh_q.idx == LAST_IDX);
        take   = enable && !ovr_err && hold_full && (!sh_q.busy || at_end);
        done   = enable && at_end && !take;
        if (!enable) begin
            sh_d = SH_RESET;
        end else if (take) begin
            sh_d.busy = 1'b1;
            sh_d.sclk = 1'b0;
            sh_d.sreg = hold_data;
            sh_d.sdo  = hold_data[0];
            sh_d.idx  = '0;
        end else if (at_end) begin
            sh_d.busy = 1'b0;
            sh_d.sclk = 1'b1;
        end else if (sh_q.busy && ev_rise && !sh_q.sclk) begin
            sh_d.sclk = 1'b1;
        end else if (sh_q.busy && ev_fall && sh_q.sclk) begin
            sh_d.sclk = 1'b0;
            sh_d.idx  = sh_q.idx + 1'b1;
            sh_d.sreg = sh_q.sreg >> 1;
            sh_d.sdo  = sh_q.sreg[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= SH_RESET;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign busy = sh_q.busy;
    assign sclk = sh_q.sclk;
    assign sdo  = sh_q.sdo;

    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_q.busy |-> sh_q.sclk); // R7

    AST_SDO_STABLE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sh_q.sclk) && sh_q.busy) |-> $stable(sh_q.sdo)); // R2

    AST_OVR_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!sh_q.busy && ovr_err) |=> !sh_q.busy); // R8

endmodule

// File: rtl/sync_serial_tx.sv
module sync_serial_tx
    import sstx_pkg::*;
#(
    parameter int unsigned CLK_DIV     = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tx_en,
    input  logic                  int_clk_sel,
    input  logic                  ext_sclk,
    input  logic                  wr_en,
    input  logic [FRAME_BITS-1:0] wr_data,
    input  logic                  ovr_err,
    input  logic                  txi_en,
    input  logic                  tei_en,
    output logic                  sclk_out,
    output logic                  sdo,
    output logic                  hre_flag,
    output logic                  tend_flag,
    output logic                  txi_req,
    output logic                  tei_req
);
    hold_st_t hs_d, hs_q;
    logic     sh_take, sh_done, sh_busy, sh_sclk, sh_sdo;
    logic     ev_rise, ev_fall;

    localparam hold_st_t HS_RESET = '{hold: '0, full: 1'b0, tend: 1'b1};

    always_comb begin
        hs_d = hs_q;
        if (!tx_en) begin
            hs_d = HS_RESET;
        end else begin
            if (sh_take) begin
                hs_d.full = 1'b0;
                hs_d.tend = 1'b0;
            end
            if (sh_done) begin
                hs_d.tend = 1'b1;
            end
            if (wr_en) begin
                hs_d.hold = wr_data;
                hs_d.full = 1'b1;
                hs_d.tend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= HS_RESET;
        end else begin
            hs_q <= hs_d;
        end
    end

    sstx_edge_src #(
        .CLK_DIV     (CLK_DIV),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .int_sel  (int_clk_sel),
        .run      (sh_busy),
        .sclk_now (sh_sclk),
        .ext_clk  (ext_sclk),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall)
    );

    sstx_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (tx_en),
        .ovr_err   (ovr_err),
        .hold_full (hs_q.full),
        .hold_data (hs_q.hold),
        .ev_rise   (ev_rise),
        .ev_fall   (ev_fall),
        .take      (sh_take),
        .done      (sh_done),
        .busy      (sh_busy),
        .sclk      (sh_sclk),
        .sdo       (sh_sdo)
    );

    assign sclk_out  = int_clk_sel ? sh_sclk : 1'b1;
    assign sdo       = sh_sdo;
    assign hre_flag  = ~hs_q.full;
    assign tend_flag = hs_q.tend;
    assign txi_req   = hre_flag & txi_en;
    assign tei_req   = tend_flag & tei_en;

    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (hre_flag && tend_flag && sdo && sclk_out)); // R9

    AST_TEND_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        hs_q.tend |-> !sh_busy); // R7

endmodule

// File: tb/sync_serial_tx_tb.sv
module sync_serial_tx_tb;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       int_clk_sel = 1'b1;
    logic       ext_sclk = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ovr_err = 1'b0;
    logic       txi_en = 1'b0;
    logic       tei_en = 1'b0;
    logic       sclk_out, sdo, hre_flag, tend_flag, txi_req, tei_req;

    int errs = 0;
    int chks = 0;
    int cyc  = 0;

    // serial monitor state
    bit         mon_on = 1'b0;
    int         rises = 0;
    int         bitc = 0;
    int         rx_n = 0;
    logic [7:0] rx_sh = '0;
    logic [7:0] rx_b [4];
    int         last_rise = 0;
    int         gap_min = 0;
    int         gap_max = 0;

    sync_serial_tx #(.CLK_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .int_clk_sel(int_clk_sel),
        .ext_sclk(ext_sclk), .wr_en(wr_en), .wr_data(wr_data), .ovr_err(ovr_err),
        .txi_en(txi_en), .tei_en(tei_en), .sclk_out(sclk_out), .sdo(sdo),
        .hre_flag(hre_flag), .tend_flag(tend_flag), .txi_req(txi_req), .tei_req(tei_req)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge sclk_out) begin
        if (mon_on) begin
            if (rises > 0) begin
                if (cyc - last_rise < gap_min) gap_min = cyc - last_rise;
                if (cyc - last_rise > gap_max) gap_max = cyc - last_rise;
            end
            last_rise = cyc;
            rises     = rises + 1;
            rx_sh     = {sdo, rx_sh[7:1]};
            bitc      = bitc + 1;
            if (bitc == 8) begin
                if (rx_n < 4) rx_b[rx_n] = rx_sh;
                rx_n = rx_n + 1;
                bitc = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        chks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic mon_clear();
        rises = 0; bitc = 0; rx_n = 0; gap_min = 1000000; gap_max = 0; mon_on = 1'b1;
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_tend(input string req);
        int n = 0;
        while (!tend_flag && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk(tend_flag == 1'b1, req, int'(tend_flag), 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hre_flag == 1'b1, "R11 empty flag", int'(hre_flag), 1);
        chk(tend_flag == 1'b1, "R11 end flag", int'(tend_flag), 1);
        chk(sdo == 1'b1, "R11 sdo", int'(sdo), 1);
        chk(sclk_out == 1'b1, "R11 sclk", int'(sclk_out), 1);
        chk(txi_req == 1'b0, "R5 txi masked", int'(txi_req), 0);
        txi_en = 1'b1; tei_en = 1'b1;
        #1;
        chk(txi_req == 1'b1, "R5 txi enabled", int'(txi_req), 1);
        chk(tei_req == 1'b1, "R5 tei enabled", int'(tei_req), 1);
        txi_en = 1'b0; tei_en = 1'b0;
        tx_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_single();
        mon_clear();
        txi_en = 1'b1; tei_en = 1'b1;
        write_byte(8'hA5);
        chk(hre_flag == 1'b0, "R4 empty cleared", int'(hre_flag), 0);
        chk(tend_flag == 1'b0, "R10 end cleared", int'(tend_flag), 0);
        chk(txi_req == 1'b0, "R5 txi low", int'(txi_req), 0);
        @(negedge clk);
        chk(hre_flag == 1'b1, "R4 empty set on load", int'(hre_flag), 1);
        chk(txi_req == 1'b1, "R5 txi high", int'(txi_req), 1);
        chk(sclk_out == 1'b0, "R2 clock low at start", int'(sclk_out), 0);
        chk(sdo == 1'b1, "R1 bit0 on line", int'(sdo), 1);
        wait_tend("R7 end flag");
        chk(rx_n == 1, "R1 frame count", rx_n, 1);
        chk(rx_b[0] == 8'hA5, "R1 byte", int'(rx_b[0]), 'hA5);
        chk(rises == 8, "R2 pulses", rises, 8);
        chk(gap_min == 2*DIV && gap_max == 2*DIV, "R2 period", gap_max, 2*DIV);
        chk(tei_req == 1'b1, "R5 tei", int'(tei_req), 1);
        repeat (20) @(negedge clk);
        chk(sdo == 1'b1, "R7 hold bit7", int'(sdo), 1);
        chk(sclk_out == 1'b1, "R7 clock high", int'(sclk_out), 1);
        chk(rises == 8, "R7 no extra pulses", rises, 8);
        tei_en = 1'b0;
        #1;
        chk(tei_req == 1'b0, "R5 tei masked", int'(tei_req), 0);
        txi_en = 1'b0;
    endtask

    task automatic t_chain();
        mon_clear();
        write_byte(8'h96);
        @(negedge clk);
        chk(hre_flag == 1'b1, "R6 first loaded", int'(hre_flag), 1);
        write_byte(8'h3C);
        wait_tend("R6 end after two");
        chk(rx_n == 2, "R6 frame count", rx_n, 2);
        chk(rx_b[0] == 8'h96, "R6 first byte", int'(rx_b[0]), 'h96);
        chk(rx_b[1] == 8'h3C, "R6 second byte", int'(rx_b[1]), 'h3C);
        chk(rises == 16, "R6 pulses", rises, 16);
        chk(gap_min == 2*DIV && gap_max == 2*DIV, "R6 no gap", gap_max, 2*DIV);
        @(negedge clk);
        chk(sdo == 1'b0, "R7 hold bit7 low", int'(sdo), 0);
    endtask

    task automatic t_ovr();
        mon_clear();
        ovr_err = 1'b1;
        write_byte(8'h5A);
        repeat (40) @(negedge clk);
        chk(rises == 0, "R8 no pulses", rises, 0);
        chk(hre_flag == 1'b0, "R8 byte kept", int'(hre_flag), 0);
        chk(sclk_out == 1'b1, "R8 clock idle", int'(sclk_out), 1);
        ovr_err = 1'b0;
        wait_tend("R8 end flag");
        chk(rx_n == 1 && rx_b[0] == 8'h5A, "R8 byte after clear", int'(rx_b[0]), 'h5A);
    endtask

    task automatic t_ext();
        logic [7:0] d = 8'hC3;
        mon_on = 1'b0;
        int_clk_sel = 1'b0; ext_sclk = 1'b0;
        repeat (6) @(negedge clk);
        write_byte(d);
        @(negedge clk);
        chk(sclk_out == 1'b1, "R3 no clock driven", int'(sclk_out), 1);
        for (int i = 0; i < 8; i++) begin
            chk(sdo == d[i], "R3 bit before rise", int'(sdo), int'(d[i]));
            ext_sclk = 1'b1;
            repeat (6) @(negedge clk);
            chk(sdo == d[i], "R3 bit after rise", int'(sdo), int'(d[i]));
            ext_sclk = 1'b0;
            repeat (6) @(negedge clk);
        end
        chk(tend_flag == 1'b1, "R3 end after eight", int'(tend_flag), 1);
        chk(sdo == d[7], "R7 ext hold bit7", int'(sdo), int'(d[7]));
        int_clk_sel = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_disable();
        mon_on = 1'b0;
        write_byte(8'hFF);
        repeat (20) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk(hre_flag == 1'b1, "R9 empty flag", int'(hre_flag), 1);
        chk(tend_flag == 1'b1, "R9 end flag", int'(tend_flag), 1);
        chk(sdo == 1'b1, "R9 sdo", int'(sdo), 1);
        chk(sclk_out == 1'b1, "R9 sclk", int'(sclk_out), 1);
        write_byte(8'h00);
        @(negedge clk);
        chk(hre_flag == 1'b1, "R9 write ignored", int'(hre_flag), 1);
        tx_en = 1'b1;
        mon_clear();
        repeat (100) @(negedge clk);
        chk(rises == 0, "R9 no frame after enable", rises, 0);
        chk(hre_flag == 1'b1, "R9 still empty", int'(hre_flag), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errs, chks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_chain();
        t_ovr();
        t_ext();
        t_disable();
        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    end

endmodule